// File: doc/BRIEF.md
# Interrupt Cycle and Character I/O Flag Controller

This block handles program interrupts and the character I/O flags of a 16-bit accumulator machine with a 12-bit address space. It holds four state bits: interrupt enable, the interrupt request, the input-ready flag and the output-done flag. It also holds a one-character input holding register, a one-character output register and a small save register for the program counter. The request is raised between instruction steps. While it is pending, the controller takes over the step slots that would otherwise fetch the next instruction. In three steps it stores the current program counter in memory word 0, forces the program counter to 1 and turns interrupts off.

The controller also executes the six I/O instructions, which the surrounding sequencer presents during the execute step. They are: load the input character into the accumulator, send the low accumulator byte out, skip if input is ready, skip if output is done, enable interrupts and disable interrupts. The input device delivers characters over a valid/ready stream. The controller accepts one character only while the input flag is clear, and holds `in_ready` low until the program consumes the character. Back-pressure toward the output device is the reverse case. A character written by the program stays on `out_data` with `out_valid` high until the device raises `out_ready`, and the flag that reports completion is set only by that handshake.

Top module: `irq_io_ctrl`

## Requirements
- R1: After reset, interrupt enable, the interrupt request and both flags are 0, `in_ready` is 1, `out_valid` is 0 and `fetch_en` is 1.
- R2: At a clock edge where none of `t0`, `t1`, `t2` is high, interrupt enable is 1 and at least one flag is 1, `irq_req` becomes 1. With interrupt enable 0 it stays 0.
- R3: When `irq_req` and `t0` are both high, `ar_clr` is 1 and the save register captures `pc`.
- R4: When `irq_req` and `t1` are both high, `mem_we` and `pc_clr` are 1, `mem_addr` is 0 and `mem_wdata` is the `pc` value from the step-0 cycle, zero-extended to 16 bits.
- R5: When `irq_req` and `t2` are both high, `pc_inc` and `sc_clr` are 1. After that edge, `irq_req` and `int_en` are 0.
- R6: `fetch_en` is the inverse of `irq_req`. With `irq_req` low, `ar_clr`, `mem_we`, `pc_clr` and `pc_inc` stay 0 under any step input.
- R7: An input handshake (`in_valid` and `in_ready` both high) stores `in_data` and sets the input flag. While that flag is 1, `in_ready` is 0 and offered characters are not taken.
- R8: Instruction F400 (bit 10) copies `ac[7:0]` to `out_data`, raises `out_valid` and clears the output flag. An output handshake drops `out_valid` and sets the output flag.
- R9: Instruction F800 (bit 11) raises `ac_load` with `ac_wdata` = {`ac[15:8]`, stored character}, and it clears the input flag.
- R10: Instruction F200 (bit 9) raises `pc_skip` exactly when the input flag is 1. Instruction F100 (bit 8) raises it exactly when the output flag is 1.
- R11: Instruction F080 (bit 7) sets interrupt enable and F040 (bit 6) clears it.
- R12: An I/O instruction acts only when `exec_t3` is high and `ir[15:12]` is 4'hF. It then also raises `sc_clr`. Any other top nibble, or a low `exec_t3`, leaves every output and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t0 | input | 1 | Timing step 0 |
| t1 | input | 1 | Timing step 1 |
| t2 | input | 1 | Timing step 2 |
| exec_t3 | input | 1 | Execute-step strobe for a register/I/O instruction |
| ir | input | 16 | Instruction register |
| ac | input | 16 | Accumulator |
| pc | input | 12 | Program counter |
| in_valid | input | 1 | Input device offers a character |
| in_ready | output | 1 | Controller can take a character |
| in_data | input | 8 | Offered character |
| out_valid | output | 1 | Character waiting for the output device |
| out_ready | input | 1 | Output device takes the character |
| out_data | output | 8 | Character to send |
| fetch_en | output | 1 | Normal fetch/decode path may run |
| ar_clr | output | 1 | Clear the address register |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| pc_clr | output | 1 | Clear the program counter |
| pc_inc | output | 1 | Increment the program counter |
| pc_skip | output | 1 | Skip the next instruction |
| sc_clr | output | 1 | Clear the sequence counter |
| ac_load | output | 1 | Load the accumulator from ac_wdata |
| ac_wdata | output | 16 | New accumulator value |
| irq_req | output | 1 | Interrupt request state |
| int_en | output | 1 | Interrupt enable state |
| flag_in | output | 1 | Input-ready flag |
| flag_out | output | 1 | Output-done flag |

## Verification
The bench walks the interrupt cycle for several program counter values, including 256, 0 and all-ones. A save register that sampled late or took the wrong width would put the wrong return address in word 0. A design that failed to clear enable on step 2 would raise the request again right away. It sweeps every top nibble with all I/O bits set, so a decoder that ignores the nibble or `exec_t3` would change enable, flags or skip. It offers a second character while the input flag is set, which catches a design that overwrites unread data. It holds `out_ready` low so that a design setting the output flag early, or dropping `out_valid`, is reported. It also drives steps with the request low, so that interrupt commands leaking into normal fetch are seen.

// File: rtl/irq_io_pkg.sv
package irq_io_pkg;
  localparam int OPC_HI    = 15;
  localparam int OPC_LO    = 12;
  localparam logic [3:0] IO_NIBBLE = 4'hF;
  localparam int BIT_INP   = 11;
  localparam int BIT_OUT   = 10;
  localparam int BIT_SKI   = 9;
  localparam int BIT_SKO   = 8;
  localparam int BIT_ION   = 7;
  localparam int BIT_IOF   = 6;

  typedef struct packed {
    logic take_in;
    logic send_out;
    logic skip_in;
    logic skip_out;
    logic ena;
    logic dis;
  } io_op_t;
endpackage

// File: rtl/irq_io_decode.sv
module irq_io_decode
  import irq_io_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              exec_t3,
  input  logic [WORD_W-1:0] ir,
  output logic              is_io,
  output io_op_t            ops
);
  always_comb begin
    is_io        = exec_t3 && (ir[OPC_HI:OPC_LO] == IO_NIBBLE);
    ops.take_in  = is_io && ir[BIT_INP];
    ops.send_out = is_io && ir[BIT_OUT];
    ops.skip_in  = is_io && ir[BIT_SKI];
    ops.skip_out = is_io && ir[BIT_SKO];
    ops.ena      = is_io && ir[BIT_ION];
    ops.dis      = is_io && ir[BIT_IOF];
  end
endmodule

// File: rtl/irq_io_flags.sv
module irq_io_flags #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  input  logic              take_in,
  input  logic              send_out,
  input  logic [CHAR_W-1:0] ac_char,
  output logic              fgi,
  output logic              fgo,
  output logic [CHAR_W-1:0] in_char
);
  logic              fgi_q, fgo_q, busy_q;
  logic [CHAR_W-1:0] inr_q, outr_q;
  logic              in_fire, out_fire;

  assign in_ready = !fgi_q;
  assign in_fire  = in_valid && !fgi_q;
  assign out_fire = busy_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fgi_q  <= 1'b0;
      fgo_q  <= 1'b0;
      busy_q <= 1'b0;
      inr_q  <= '0;
      outr_q <= '0;
    end else begin
      if (in_fire) begin
        inr_q <= in_data;
        fgi_q <= 1'b1;
      end else if (take_in) begin
        fgi_q <= 1'b0;
      end
      if (send_out) begin
        outr_q <= ac_char;
        busy_q <= 1'b1;
        fgo_q  <= 1'b0;
      end else if (out_fire) begin
        busy_q <= 1'b0;
        fgo_q  <= 1'b1;
      end
    end
  end

  assign out_valid = busy_q;
  assign out_data  = outr_q;
  assign fgi       = fgi_q;
  assign fgo       = fgo_q;
  assign in_char   = inr_q;
endmodule

// File: rtl/irq_io_seq.sv
module irq_io_seq #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t0,
  input  logic              t1,
  input  logic              t2,
  input  logic [ADDR_W-1:0] pc,
  input  logic              fgi,
  input  logic              fgo,
  input  logic              ena,
  input  logic              dis,
  output logic              irq_q,
  output logic              ien_q,
  output logic [ADDR_W-1:0] save_q,
  output logic              step0,
  output logic              step1,
  output logic              step2
);
  logic between;

  assign between = !(t0 || t1 || t2);
  assign step0   = irq_q && t0;
  assign step1   = irq_q && t1;
  assign step2   = irq_q && t2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      ien_q  <= 1'b0;
      save_q <= '0;
    end else begin
      if (step2) begin
        irq_q <= 1'b0;
        ien_q <= 1'b0;
      end else begin
        if (between && ien_q && (fgi || fgo)) irq_q <= 1'b1;
        if (ena)      ien_q <= 1'b1;
        else if (dis) ien_q <= 1'b0;
      end
      if (step0) save_q <= pc;
    end
  end
endmodule

// File: rtl/irq_io_ctrl.sv
module irq_io_ctrl
  import irq_io_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WORD_W    = 16,
  parameter int CHAR_W    = 8,
  parameter int SAVE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t0,
  input  logic              t1,
  input  logic              t2,
  input  logic              exec_t3,
  input  logic [WORD_W-1:0] ir,
  input  logic [WORD_W-1:0] ac,
  input  logic [ADDR_W-1:0] pc,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic              fetch_en,
  output logic              ar_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              pc_clr,
  output logic              pc_inc,
  output logic              pc_skip,
  output logic              sc_clr,
  output logic              ac_load,
  output logic [WORD_W-1:0] ac_wdata,
  output logic              irq_req,
  output logic              int_en,
  output logic              flag_in,
  output logic              flag_out
);
  localparam int PAD_W = WORD_W - ADDR_W;
  localparam int HI_W  = WORD_W - CHAR_W;

  io_op_t            ops;
  logic              is_io;
  logic              fgi, fgo, irq_q, ien_q, step0, step1, step2;
  logic [CHAR_W-1:0] in_char;
  logic [ADDR_W-1:0] save_q;

  irq_io_decode #(.WORD_W(WORD_W)) u_dec (
    .exec_t3(exec_t3), .ir(ir), .is_io(is_io), .ops(ops)
  );

  irq_io_flags #(.CHAR_W(CHAR_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .take_in(ops.take_in), .send_out(ops.send_out), .ac_char(ac[CHAR_W-1:0]),
    .fgi(fgi), .fgo(fgo), .in_char(in_char)
  );

  irq_io_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .t0(t0), .t1(t1), .t2(t2), .pc(pc),
    .fgi(fgi), .fgo(fgo), .ena(ops.ena), .dis(ops.dis),
    .irq_q(irq_q), .ien_q(ien_q), .save_q(save_q),
    .step0(step0), .step1(step1), .step2(step2)
  );

  assign fetch_en  = !irq_q;
  assign ar_clr    = step0;
  assign mem_we    = step1;
  assign mem_addr  = ADDR_W'(SAVE_ADDR);
  assign mem_wdata = {{PAD_W{1'b0}}, save_q};
  assign pc_clr    = step1;
  assign pc_inc    = step2;
  assign sc_clr    = step2 || is_io;
  assign pc_skip   = (ops.skip_in && fgi) || (ops.skip_out && fgo);
  assign ac_load   = ops.take_in;
  assign ac_wdata  = {ac[WORD_W-1:CHAR_W], in_char};
  assign irq_req   = irq_q;
  assign int_en    = ien_q;
  assign flag_in   = fgi;
  assign flag_out  = fgo;

  initial begin
    assert (HI_W > 0 && PAD_W >= 0);
  end
endmodule

// File: rtl/irq_io_ctrl_chk.sv
module irq_io_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              t0,
  input logic              t1,
  input logic              t2,
  input logic              exec_t3,
  input logic [WORD_W-1:0] ir,
  input logic [ADDR_W-1:0] pc,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              irq_req,
  input logic              int_en,
  input logic              flag_in,
  input logic              flag_out
);
  p_steps_onehot_env: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({t0, t1, t2}));

  p_irq_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!t0 && !t1 && !t2 && int_en && (flag_in || flag_out)) |=> irq_req);

  p_irq_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !int_en) |=> !irq_req);

  p_save_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_req && t0) && irq_req && t1) |-> (mem_wdata == WORD_W'($past(pc))));

  p_irq_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && t2) |=> (!irq_req && !int_en));

  p_write_only_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (irq_req && t1));

  p_in_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (flag_in && !in_ready));

  p_out_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !(exec_t3 && ir[15:12] == 4'hF && ir[10])) |=> (flag_out && !out_valid));

  p_ion_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_t3 && ir == 16'hF080 && !(irq_req && t2)) |=> int_en);
endmodule

bind irq_io_ctrl irq_io_ctrl_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/irq_io_ctrl_bench.sv
`timescale 1ns/1ps
module irq_io_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        t0, t1, t2, exec_t3;
  logic [15:0] ir, ac;
  logic [11:0] pc;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [7:0]  in_data, out_data;
  logic        fetch_en, ar_clr, mem_we, pc_clr, pc_inc, pc_skip, sc_clr, ac_load;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, ac_wdata;
  logic        irq_req, int_en, flag_in, flag_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_io_ctrl u_irq_io_ctrl (
    .clk(clk), .rst_n(rst_n), .t0(t0), .t1(t1), .t2(t2), .exec_t3(exec_t3),
    .ir(ir), .ac(ac), .pc(pc),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fetch_en(fetch_en), .ar_clr(ar_clr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pc_clr(pc_clr), .pc_inc(pc_inc), .pc_skip(pc_skip),
    .sc_clr(sc_clr), .ac_load(ac_load), .ac_wdata(ac_wdata),
    .irq_req(irq_req), .int_en(int_en), .flag_in(flag_in), .flag_out(flag_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic io_on(input logic [15:0] code);
    ir = code;
    exec_t3 = 1'b1;
    #0.5;
  endtask

  task automatic io_off();
    tick();
    exec_t3 = 1'b0;
    ir = 16'h0000;
    #0.5;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; t0 = 0; t1 = 0; t2 = 0; exec_t3 = 0;
    ir = 0; ac = 0; pc = 0; in_valid = 0; in_data = 0; out_ready = 0;
    repeat (3) tick();
    // R1 reset state
    chk("R1 int_en", int_en, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 flags", {flag_in, flag_out}, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 fetch_en", fetch_en, 1);
    rst_n = 1'b1;
    tick();

    // R6: steps with no request give no interrupt commands
    for (int s = 0; s < 3; s++) begin
      t0 = (s == 0); t1 = (s == 1); t2 = (s == 2);
      #0.5;
      chk("R6 no commands", {ar_clr, mem_we, pc_clr, pc_inc}, 0);
      tick();
    end
    t0 = 0; t1 = 0; t2 = 0;

    // R12: sweep of all non-I/O nibbles with every I/O bit set
    ac = 16'h5A5A;
    for (int nib = 0; nib < 15; nib++) begin
      io_on({nib[3:0], 12'hFC0});
      chk("R12 sc_clr", sc_clr, 0);
      chk("R12 skip/load", {pc_skip, ac_load}, 0);
      io_off();
      chk("R12 state", {int_en, out_valid, flag_in, flag_out, in_ready}, 5'b00001);
    end
    // R12: I/O code without the execute strobe
    ir = 16'hF480; exec_t3 = 1'b0; #0.5;
    chk("R12 no strobe sc_clr", sc_clr, 0);
    tick();
    chk("R12 no strobe state", {int_en, out_valid}, 0);
    ir = 0;

    // R11 enable and disable
    io_on(16'hF080);
    chk("R12 sc_clr on io", sc_clr, 1);
    io_off();
    chk("R11 ion", int_en, 1);
    chk("R2 no flags no irq", irq_req, 0);
    tick();
    chk("R2 no flags no irq idle", irq_req, 0);
    io_on(16'hF040);
    io_off();
    chk("R11 iof", int_en, 0);

    // R7, R9, R10: input path
    for (int i = 0; i < 4; i++) begin
      logic [7:0] ch;
      ch = 8'h41 + 8'(i * 37);
      in_valid = 1'b1; in_data = ch; #0.5;
      chk("R7 ready empty", in_ready, 1);
      io_on(16'hF200);
      chk("R10 ski empty", pc_skip, 0);
      io_off();
      in_valid = 1'b0;
      chk("R7 flag set", {flag_in, in_ready}, 2'b10);
      in_valid = 1'b1; in_data = ~ch;
      tick();
      in_valid = 1'b0;
      io_on(16'hF200);
      chk("R10 ski full", pc_skip, 1);
      io_off();
      io_on(16'hF100);
      chk("R10 sko", pc_skip, {31'd0, flag_out});
      io_off();
      ac = 16'hBE00 | 16'(i);
      io_on(16'hF800);
      chk("R9 ac_load", ac_load, 1);
      chk("R9 ac_wdata", ac_wdata, {8'hBE, ch});
      io_off();
      chk("R9 flag cleared", {flag_in, in_ready}, 2'b01);
    end

    // R8, R10: output path
    for (int i = 0; i < 4; i++) begin
      logic [15:0] v;
      v = 16'h12A5 + 16'(i * 16'h3311);
      ac = v;
      io_on(16'hF400);
      chk("R12 sc_clr out", sc_clr, 1);
      io_off();
      chk("R8 out_data", out_data, v[7:0]);
      chk("R8 pending", {out_valid, flag_out}, 2'b10);
      io_on(16'hF100);
      chk("R10 sko busy", pc_skip, 0);
      io_off();
      chk("R8 held", {out_valid, flag_out}, 2'b10);
      out_ready = 1'b1;
      tick();
      out_ready = 1'b0; #0.5;
      chk("R8 done", {out_valid, flag_out}, 2'b01);
      io_on(16'hF100);
      chk("R10 sko done", pc_skip, 1);
      io_off();
    end

    // R2 negative: flag set, enable off
    tick();
    chk("R2 disabled", irq_req, 0);

    // R2..R6 interrupt cycle for several return addresses
    for (int k = 0; k < 4; k++) begin
      logic [11:0] p;
      case (k)
        0: p = 12'd256;
        1: p = 12'hFFF;
        2: p = 12'h000;
        default: p = 12'hABC;
      endcase
      io_on(16'hF080);
      io_off();
      chk("R11 ion", int_en, 1);
      chk("R2 not yet", irq_req, 0);
      tick();
      chk("R2 raised", irq_req, 1);
      chk("R6 fetch off", fetch_en, 0);
      pc = p; t0 = 1'b1; #0.5;
      chk("R3 ar_clr", ar_clr, 1);
      chk("R3 no write", mem_we, 0);
      tick();
      t0 = 1'b0; t1 = 1'b1; pc = ~p; #0.5;
      chk("R4 write", {mem_we, pc_clr}, 2'b11);
      chk("R4 addr", mem_addr, 0);
      chk("R4 data", mem_wdata, {4'h0, p});
      tick();
      t1 = 1'b0; t2 = 1'b1; #0.5;
      chk("R5 inc", {pc_inc, sc_clr}, 2'b11);
      tick();
      t2 = 1'b0; #0.5;
      chk("R5 exit", {irq_req, int_en}, 0);
      chk("R6 fetch on", fetch_en, 1);
      tick();
      chk("R2 stays off", irq_req, 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule